// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. It divides the system clock to make oversample ticks: 16 ticks per bit in normal mode and 8 in double-speed mode. It finds a falling start edge and takes each bit as the majority vote of three ticks around the middle of the bit. It assembles frames of 5 to 9 data bits, with optional parity, into a single-entry receive buffer. With the buffer it keeps three error flags: frame error, parity error and overrun.

In multi-processor mode only address frames reach the buffer, and data frames leave no trace. Clearing the enable empties the buffer and invalidates every flag. An interrupt request is raised when its own enable, the global enable and the receive-complete flag are all set.

Top module: `srx_top`

## Requirements
- R1: One bit lasts (baud_div+1)*16 clocks when dbl_speed=0 and (baud_div+1)*8 clocks when dbl_speed=1. Bits are sampled on the three middle oversample ticks (7,8,9 of 16; 3,4,5 of 8) and the majority value is taken.
- R2: char_code selects the data width: 000=5, 001=6, 010=7, 011=8, 111=9 bits; any other code means 8. Data arrives LSB first. rx_data holds the low 8 bits with unused upper bits zero. rx_bit8 holds the ninth bit in 9-bit mode and is 0 otherwise.
- R3: A start bit whose majority sample is high is dropped. The receiver then returns to hunting for a start edge and stores nothing.
- R4: par_mode[1]=1 adds a parity bit after the data; par_mode[0]=1 selects odd parity and 0 selects even. err_parity is set with the stored frame when the parity does not match, and cleared otherwise.
- R5: err_frame is set with the stored frame when the stop bit samples low, and cleared otherwise.
- R6: If a frame is accepted while rx_done is set and no read happens in that cycle, err_overrun is set and rx_data, rx_bit8 keep the older frame.
- R7: A one-cycle rd_strobe clears rx_done and err_overrun.
- R8: When mp_mode=1, a frame whose address marker is 0 is ignored: buffer and flags are unchanged. The marker is the ninth bit in 9-bit frames and the stop bit otherwise.
- R9: While rx_en=0, rx_done and all error flags read 0 the cycle after, and frames on rxd are ignored.
- R10: pin_claim is 1 exactly while rx_en is 1.
- R11: irq is 1 exactly when irq_en, gie and rx_done are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer and flags |
| dbl_speed | input | 1 | 1 selects 8 oversample ticks per bit |
| mp_mode | input | 1 | Multi-processor address filter enable |
| char_code | input | 3 | Character size code |
| par_mode | input | 2 | Parity: bit 1 enable, bit 0 odd |
| baud_div | input | DIV_W | Clocks per oversample tick minus one |
| rxd | input | 1 | Serial input line (idle high) |
| rd_strobe | input | 1 | Buffer read pulse |
| irq_en | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rx_data | output | 8 | Received data, low 8 bits |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_done | output | 1 | Receive-complete flag |
| err_frame | output | 1 | Frame error flag |
| err_overrun | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| pin_claim | output | 1 | Receiver owns the serial input pin |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench sweeps every character size against none, even and odd parity with several data patterns. A design that aligned the shift register wrongly would leave stray bits in rx_data or rx_bit8. A design that counted parity over the wrong bits would flag clean frames. A three-cycle low glitch on an idle line checks that false starts are rejected; a design that skipped the vote would store a phantom frame. The bench also drives back-to-back frames with no read, data frames and stop-low frames in address mode, a disable with pending errors, double speed and a slower divider. A mishandled overrun would overwrite the older byte. A leaky filter would set rx_done or err_frame. A wrong oversample count would misalign the bits and garble the data.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OS_NORMAL = 16;
    localparam int OS_DOUBLE = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] word;
        logic       ferr;
        logic       perr;
        logic       marker;
    } rx_frame_t;

    function automatic logic [3:0] char_bits(input logic [2:0] code);
        case (code)
            3'b000:  return 4'd5;
            3'b001:  return 4'd6;
            3'b010:  return 4'd7;
            3'b011:  return 4'd8;
            3'b111:  return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/srx_sampler.sv
module srx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], din};
        end
    end

    assign dout = chain[SYNC_STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       dbl,
    input  logic       line,
    input  logic [2:0] char_code,
    input  logic [1:0] par_mode,
    output logic       push,
    output rx_frame_t  frame
);
    rx_state_e  st;
    logic [3:0] os_cnt;
    logic [1:0] votes;
    logic [3:0] bit_idx;
    logic [8:0] sh;
    logic       par_acc;
    logic       perr_r;

    logic [3:0] nb;
    logic [3:0] mid_lo;
    logic [3:0] last;
    logic       maj;
    logic       dec;
    logic [8:0] aligned;

    always_comb begin
        nb      = char_bits(char_code);
        mid_lo  = dbl ? 4'd3 : 4'd7;
        last    = dbl ? 4'(OS_DOUBLE - 1) : 4'(OS_NORMAL - 1);
        maj     = vote3(votes[1], votes[0], line);
        dec     = tick && (st != ST_IDLE) && (os_cnt == mid_lo + 4'd2);
        aligned = sh >> (4'd9 - nb);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st      <= ST_IDLE;
            os_cnt  <= '0;
            votes   <= '0;
            bit_idx <= '0;
            sh      <= '0;
            par_acc <= 1'b0;
            perr_r  <= 1'b0;
            push    <= 1'b0;
            frame   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                if (st == ST_IDLE) begin
                    if (!line) begin
                        st     <= ST_START;
                        os_cnt <= 4'd1;
                    end
                end else begin
                    os_cnt <= (os_cnt == last) ? 4'd0 : os_cnt + 4'd1;
                    if (os_cnt == mid_lo || os_cnt == mid_lo + 4'd1) begin
                        votes <= {votes[0], line};
                    end
                end
            end
            if (dec) begin
                unique case (st)
                    ST_START: begin
                        if (maj) begin
                            st <= ST_IDLE;
                        end else begin
                            st      <= ST_DATA;
                            bit_idx <= '0;
                            par_acc <= 1'b0;
                            perr_r  <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        sh      <= {maj, sh[8:1]};
                        par_acc <= par_acc ^ maj;
                        if (bit_idx == nb - 4'd1) begin
                            st <= par_mode[1] ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                    ST_PAR: begin
                        perr_r <= par_acc ^ maj ^ par_mode[0];
                        st     <= ST_STOP;
                    end
                    ST_STOP: begin
                        push         <= 1'b1;
                        frame.word   <= aligned;
                        frame.ferr   <= !maj;
                        frame.perr   <= perr_r;
                        frame.marker <= (nb == 4'd9) ? aligned[8] : maj;
                        st           <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       accept,
    input  rx_frame_t  frame,
    input  logic       rd,
    output logic [7:0] data,
    output logic       bit8,
    output logic       done,
    output logic       ferr,
    output logic       perr,
    output logic       ovr
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            data <= '0;
            bit8 <= 1'b0;
            done <= 1'b0;
            ferr <= 1'b0;
            perr <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (rd) begin
                done <= 1'b0;
                ovr  <= 1'b0;
            end
            if (accept) begin
                if (done && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    data <= frame.word[7:0];
                    bit8 <= frame.word[8];
                    ferr <= frame.ferr;
                    perr <= frame.perr;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             dbl_speed,
    input  logic             mp_mode,
    input  logic [2:0]       char_code,
    input  logic [1:0]       par_mode,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rxd,
    input  logic             rd_strobe,
    input  logic             irq_en,
    input  logic             gie,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             rx_done,
    output logic             err_frame,
    output logic             err_overrun,
    output logic             err_parity,
    output logic             pin_claim,
    output logic             irq
);
    logic      os_tick;
    logic      line_s;
    logic      frm_push;
    logic      frm_accept;
    rx_frame_t frm;

    srx_tick #(.DIV_W(DIV_W)) tick_i (
        .clk (clk),
        .rst (rst),
        .en  (rx_en),
        .div (baud_div),
        .tick(os_tick)
    );

    srx_sampler #(.SYNC_STAGES(2)) samp_i (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(line_s)
    );

    srx_frame frame_i (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en),
        .tick     (os_tick),
        .dbl      (dbl_speed),
        .line     (line_s),
        .char_code(char_code),
        .par_mode (par_mode),
        .push     (frm_push),
        .frame    (frm)
    );

    assign frm_accept = frm_push && (!mp_mode || frm.marker);

    srx_buffer buf_i (
        .clk   (clk),
        .rst   (rst),
        .en    (rx_en),
        .accept(frm_accept),
        .frame (frm),
        .rd    (rd_strobe),
        .data  (rx_data),
        .bit8  (rx_bit8),
        .done  (rx_done),
        .ferr  (err_frame),
        .perr  (err_parity),
        .ovr   (err_overrun)
    );

    assign pin_claim = rx_en;
    assign irq       = irq_en && gie && rx_done;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       rd_strobe,
    input logic       irq_en,
    input logic       gie,
    input logic       frm_accept,
    input logic [7:0] rx_data,
    input logic       rx_done,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       pin_claim,
    input logic       irq
);
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_done && irq_en && gie));

    assert_irq_raise_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_done && irq_en && gie) |-> irq);

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_done && !err_frame && !err_overrun && !err_parity));

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rx_en && !frm_accept) |=> (!rx_done && !err_overrun));

    assert_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_accept && rx_done && !rd_strobe && rx_en) |=> (err_overrun && $stable(rx_data)));

    assert_done_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(frm_accept));

    assert_pin_claim_R10: assert property (@(posedge clk) disable iff (rst)
        pin_claim == rx_en);
endmodule

bind srx_top srx_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .rd_strobe  (rd_strobe),
    .irq_en     (irq_en),
    .gie        (gie),
    .frm_accept (frm_accept),
    .rx_data    (rx_data),
    .rx_done    (rx_done),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .err_parity (err_parity),
    .pin_claim  (pin_claim),
    .irq        (irq)
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;
    localparam int CLK_T = 10;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_en = 1'b0;
    logic             dbl_speed = 1'b0;
    logic             mp_mode = 1'b0;
    logic [2:0]       char_code = 3'b011;
    logic [1:0]       par_mode = 2'b00;
    logic [DIV_W-1:0] baud_div = '0;
    logic             rxd = 1'b1;
    logic             rd_strobe = 1'b0;
    logic             irq_en = 1'b0;
    logic             gie = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_bit8;
    logic             rx_done;
    logic             err_frame;
    logic             err_overrun;
    logic             err_parity;
    logic             pin_claim;
    logic             irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_T / 2) clk = ~clk;

    srx_top #(.DIV_W(DIV_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .dbl_speed  (dbl_speed),
        .mp_mode    (mp_mode),
        .char_code  (char_code),
        .par_mode   (par_mode),
        .baud_div   (baud_div),
        .rxd        (rxd),
        .rd_strobe  (rd_strobe),
        .irq_en     (irq_en),
        .gie        (gie),
        .rx_data    (rx_data),
        .rx_bit8    (rx_bit8),
        .rx_done    (rx_done),
        .err_frame  (err_frame),
        .err_overrun(err_overrun),
        .err_parity (err_parity),
        .pin_claim  (pin_claim),
        .irq        (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_clks();
        return (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
    endfunction

    function automatic logic [2:0] code_of(input int nb);
        return (nb == 9) ? 3'b111 : 3'(nb - 5);
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (bit_clks()) @(negedge clk);
    endtask

    // sends start, nb data bits LSB first, optional parity, stop; then 2 idle bits
    task automatic send(input logic [8:0] d, input int nb, input logic bad_par,
                        input logic stopv);
        logic p;
        p = par_mode[0];
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i]);
            p = p ^ d[i];
        end
        if (par_mode[1]) drive_bit(p ^ bad_par);
        drive_bit(stopv);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] d;
        int exp_data;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R9 reset done", rx_done, 0);
        chk("R9 reset flags", {err_frame, err_overrun, err_parity}, 0);
        chk("R10 pin released", pin_claim, 0);
        chk("R11 irq idle", irq, 0);

        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 pin claimed", pin_claim, 1);

        // R1 R2 R4 R5: sweep sizes x parity modes x patterns
        for (int nb = 5; nb <= 9; nb++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 3; k++) begin
                    char_code = code_of(nb);
                    par_mode = (pm == 0) ? 2'b00 : (pm == 1) ? 2'b10 : 2'b11;
                    d = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : 9'(9'h0A5 ^ (nb * 37));
                    send(d, nb, 1'b0, 1'b1);
                    exp_data = int'(d[7:0]) & ((1 << ((nb > 8) ? 8 : nb)) - 1);
                    chk("R2 data", rx_data, exp_data);
                    chk("R2 bit8", rx_bit8, (nb == 9) ? int'(d[8]) : 0);
                    chk("R1 done", rx_done, 1);
                    chk("R4 no perr", err_parity, 0);
                    chk("R5 no ferr", err_frame, 0);
                    do_read();
                    chk("R7 read clears", rx_done, 0);
                end
            end
        end

        // R4 parity error, even and odd
        char_code = 3'b011;
        par_mode = 2'b10;
        send(9'h03C, 8, 1'b1, 1'b1);
        chk("R4 even perr", err_parity, 1);
        do_read();
        par_mode = 2'b11;
        send(9'h081, 8, 1'b1, 1'b1);
        chk("R4 odd perr", err_parity, 1);
        chk("R4 data kept", rx_data, 8'h81);
        do_read();
        par_mode = 2'b00;

        // R5 frame error
        send(9'h055, 8, 1'b0, 1'b0);
        chk("R5 ferr", err_frame, 1);
        chk("R5 done", rx_done, 1);
        do_read();

        // R6 overrun, R7 clears it
        send(9'h011, 8, 1'b0, 1'b1);
        send(9'h022, 8, 1'b0, 1'b1);
        chk("R6 overrun", err_overrun, 1);
        chk("R6 old data kept", rx_data, 8'h11);
        do_read();
        chk("R7 ovr cleared", err_overrun, 0);
        chk("R7 done cleared", rx_done, 0);

        // R3 start glitch rejected
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (14 * 16) @(negedge clk);
        chk("R3 glitch ignored", rx_done, 0);
        send(9'h0C3, 8, 1'b0, 1'b1);
        chk("R3 recovers", rx_data, 8'hC3);
        do_read();

        // R8 address filter, 9-bit
        mp_mode = 1'b1;
        char_code = 3'b111;
        send(9'h0F3, 9, 1'b0, 1'b1);
        chk("R8 data frame dropped", rx_done, 0);
        send(9'h1C4, 9, 1'b0, 1'b1);
        chk("R8 address accepted", rx_done, 1);
        chk("R8 address data", rx_data, 8'hC4);
        chk("R8 address bit8", rx_bit8, 1);
        do_read();
        // R8 address filter, 8-bit: stop bit is the marker
        char_code = 3'b011;
        send(9'h077, 8, 1'b0, 1'b0);
        chk("R8 marker0 dropped", rx_done, 0);
        chk("R8 no ferr leak", err_frame, 0);
        send(9'h078, 8, 1'b0, 1'b1);
        chk("R8 marker1 accepted", rx_data, 8'h78);
        do_read();
        mp_mode = 1'b0;

        // R11 irq gating
        send(9'h0AA, 8, 1'b0, 1'b1);
        for (int c = 0; c < 4; c++) begin
            irq_en = c[0];
            gie = c[1];
            @(negedge clk);
            chk("R11 irq with done", irq, int'(c[0] & c[1]));
        end
        do_read();
        chk("R11 irq after read", irq, 0);
        irq_en = 1'b0;
        gie = 1'b0;

        // R9 flush on disable
        send(9'h012, 8, 1'b0, 1'b0);
        send(9'h034, 8, 1'b0, 1'b1);
        chk("R9 pre ferr", err_frame, 1);
        chk("R9 pre ovr", err_overrun, 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R9 flushed done", rx_done, 0);
        chk("R9 flushed flags", {err_frame, err_overrun, err_parity}, 0);
        chk("R10 released", pin_claim, 0);
        send(9'h05A, 8, 1'b0, 1'b1);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 ignored while off", rx_done, 0);

        // R1 double speed
        dbl_speed = 1'b1;
        send(9'h05A, 8, 1'b0, 1'b1);
        chk("R1 double speed data", rx_data, 8'h5A);
        chk("R1 double speed done", rx_done, 1);
        do_read();
        dbl_speed = 1'b0;

        // R1 slower divider, 7-bit even parity
        baud_div = 8'd2;
        char_code = 3'b010;
        par_mode = 2'b10;
        send(9'h04D, 7, 1'b0, 1'b1);
        chk("R1 divider data", rx_data, 8'h4D);
        chk("R1 divider perr", err_parity, 0);
        do_read();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule